// File: doc/BRIEF.md
# CAN Controller Mode and Status Register

This block is the software-facing mode and status register of a CAN protocol controller. The CPU writes an initialization request, a sleep request, a stop request and two pin-polarity bits. The block passes these on to the protocol layer as level requests. It raises its initialized flag only when the protocol layer answers with a one-cycle acknowledge. While that flag is up, the block forces the transmit pin to the recessive level, holds both error counters at zero, and opens the write path to the synchronization and baud-prescaler registers.

The block also keeps the transmit and receive error counters. It classifies each counter into a two-bit error state and derives the bus-off flag from the transmit counter. It registers the transmitting and receiving activity reported by the protocol engine. Between the engine's logical dominant bit and the physical pins, it applies a separately programmable dominant level for each direction. The engine, the bit-timing logic and the message storage are outside this block. They appear only as request, acknowledge, busy, error-step and bit signals.

Top module: `can_mode_reg`

## Requirements
- R1: `statBusOff` is 1 exactly when the transmit error count is 256 or more.
- R2: `statTx` and `statRx` equal `txBusy` and `rxBusy` as sampled at the previous clock edge.
- R3: `statInit` rises only on the edge after a `protoAck` pulse that arrives while `modeInit` or `modeStop` is 1. An acknowledge arriving while both are 0 has no effect. `statInit` falls on the first edge at which both `modeInit` and `modeStop` are already 0.
- R4: While `statInit` is 1, `canTxPin` sits at the recessive level, which is the inverse of the transmit polarity bit, whatever `txBitDom` is.
- R5: A write to address 1 (synchronization, 8 bits) or address 2 (prescaler, 6 bits) updates `syncVal` or `prescVal` only while `statInit` is 1. Otherwise the write is ignored.
- R6: While `statInit` is 1, both error counters are cleared and held at 0, and both error-state fields read 0.
- R7: With the receive polarity bit (address 0, bit 3) at 0, a low `canRxPin` gives `rxBitDom` = 1. With the bit at 1, a high `canRxPin` gives `rxBitDom` = 1.
- R8: Outside initialization, with the transmit polarity bit (address 0, bit 4) at 0, a dominant `txBitDom` drives `canTxPin` low and a recessive one drives it high. With the bit at 1, both levels are inverted.
- R9: The stop bit (address 0, bit 2) can be set only if the sleep bit is already 1. A write that sets stop while sleep is 0 leaves it at 0. Once stop is set, only a control write with bit 2 at 0 clears it, even if that write clears sleep.
- R10: Each error-state field encodes the counter as follows: 0 below 96, 1 from 96 to 127, 2 from 128 to 255, and 3 at 256 or more.
- R11: Each cycle with `txErrUp` adds 8 to the transmit counter, and each cycle with `rxErrUp` adds 1 to the receive counter. Each cycle with a down strobe and no up strobe subtracts 1. Counters saturate at 511 and at 0.
- R12: A control write to address 0 places bit 0 on `modeInit`, bit 1 on `modeSleep` and bit 2 (subject to R9) on `modeStop`, one edge after the write. All outputs reset to 0, and `canTxPin` resets to the recessive high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | CPU write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 synchronization, 2 prescaler |
| wrData | input | 8 | Write data |
| protoAck | input | 1 | One-cycle acknowledge of the init/stop request from the protocol layer |
| txBusy | input | 1 | Protocol engine is sending a frame |
| rxBusy | input | 1 | Protocol engine is receiving a frame |
| txErrUp | input | 1 | Transmit error: step the transmit counter up |
| txErrDown | input | 1 | Transmit success: step the transmit counter down |
| rxErrUp | input | 1 | Receive error: step the receive counter up |
| rxErrDown | input | 1 | Receive success: step the receive counter down |
| txBitDom | input | 1 | Engine's transmit bit, 1 = dominant |
| canRxPin | input | 1 | Physical receive pin |
| modeInit | output | 1 | Initialization request to the protocol layer |
| modeSleep | output | 1 | Sleep request to the protocol layer |
| modeStop | output | 1 | Stop request to the protocol layer |
| statInit | output | 1 | Initialized (acknowledged) status |
| statBusOff | output | 1 | Bus-off status |
| statTx | output | 1 | Transmitting status |
| statRx | output | 1 | Receiving status |
| txErrCnt | output | 9 | Transmit error counter |
| rxErrCnt | output | 9 | Receive error counter |
| txErrState | output | 2 | Transmit error-state field |
| rxErrState | output | 2 | Receive error-state field |
| syncVal | output | 8 | Synchronization register contents |
| prescVal | output | 6 | Baud prescaler register contents |
| canTxPin | output | 1 | Physical transmit pin |
| rxBitDom | output | 1 | Receive bit to the engine, 1 = dominant |

## Verification
The init handshake is driven first with an acknowledge that is delayed for several cycles and then with an acknowledge sent while nothing was requested. This separates an initialized flag that follows the acknowledge from one that follows the written bit. The error counters are walked across every threshold in both directions and into saturation, so an off-by-one comparison or a wrong step size shows up as a wrong state code. The stop bit is written in each order relative to sleep, and all four polarity combinations are tried on both pins, both inside and outside initialization. A swapped inversion or a missing recessive override therefore shows on the pin levels.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_SYNC = 1;
  localparam int ADDR_PRESC = 2;

  localparam int BIT_INIT = 0;
  localparam int BIT_SLEEP = 1;
  localparam int BIT_STOP = 2;
  localparam int BIT_RXPOL = 3;
  localparam int BIT_TXPOL = 4;

  typedef enum logic [1:0] {
    ERR_ACTIVE  = 2'd0,
    ERR_WARN    = 2'd1,
    ERR_PASSIVE = 2'd2,
    ERR_BUSOFF  = 2'd3
  } errState_e;

  // Strobes and levels passed from control to datapath
  typedef struct packed {
    logic clrErr;
    logic forceRec;
    logic syncWr;
    logic prescWr;
    logic txPol;
    logic rxPol;
  } modeStrobe_t;

endpackage

// File: rtl/can_err_counter.sv
module can_err_counter
  import can_mode_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int STEP = 8,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128,
  parameter int OFF_LVL = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             up,
  input  logic             down,
  output logic [CNT_W-1:0] cnt,
  output logic [1:0]       state
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] HEADROOM = CNT_MAX - STEP_V;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (up) begin
      cnt <= (cnt > HEADROOM) ? CNT_MAX : cnt + STEP_V;
    end else if (down && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  errState_e stateE;

  always_comb begin
    if (int'(cnt) >= OFF_LVL) stateE = ERR_BUSOFF;
    else if (int'(cnt) >= PASS_LVL) stateE = ERR_PASSIVE;
    else if (int'(cnt) >= WARN_LVL) stateE = ERR_WARN;
    else stateE = ERR_ACTIVE;
  end

  assign state = stateE;

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              protoAck,
  output logic              modeInit,
  output logic              modeSleep,
  output logic              modeStop,
  output logic              statInit,
  output modeStrobe_t       strb
);

  logic ctrlWr;
  logic txPolQ;
  logic rxPolQ;
  logic reqActive;

  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));
  assign reqActive = modeInit | modeStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeInit  <= 1'b0;
      modeSleep <= 1'b0;
      modeStop  <= 1'b0;
      txPolQ    <= 1'b0;
      rxPolQ    <= 1'b0;
    end else if (ctrlWr) begin
      modeInit  <= wrData[BIT_INIT];
      modeSleep <= wrData[BIT_SLEEP];
      // stop is entered only from sleep, left only by writing 0
      modeStop  <= wrData[BIT_STOP] & (modeStop | modeSleep);
      txPolQ    <= wrData[BIT_TXPOL];
      rxPolQ    <= wrData[BIT_RXPOL];
    end
  end

  // Initialized flag tracks the protocol layer acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statInit <= 1'b0;
    end else if (!reqActive) begin
      statInit <= 1'b0;
    end else if (protoAck) begin
      statInit <= 1'b1;
    end
  end

  always_comb begin
    strb.clrErr   = statInit;
    strb.forceRec = statInit;
    strb.syncWr   = statInit && wrEn && (wrAddr == ADDR_W'(ADDR_SYNC));
    strb.prescWr  = statInit && wrEn && (wrAddr == ADDR_W'(ADDR_PRESC));
    strb.txPol    = txPolQ;
    strb.rxPol    = rxPolQ;
  end

endmodule

// File: rtl/can_mode_dp.sv
module can_mode_dp
  import can_mode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 9,
  parameter int SYNC_W = 8,
  parameter int PRESC_W = 6,
  parameter int TX_STEP = 8,
  parameter int RX_STEP = 1,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128,
  parameter int OFF_LVL = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  modeStrobe_t        strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               txBusy,
  input  logic               rxBusy,
  input  logic               txErrUp,
  input  logic               txErrDown,
  input  logic               rxErrUp,
  input  logic               rxErrDown,
  input  logic               txBitDom,
  input  logic               canRxPin,
  output logic               statBusOff,
  output logic               statTx,
  output logic               statRx,
  output logic [CNT_W-1:0]   txErrCnt,
  output logic [CNT_W-1:0]   rxErrCnt,
  output logic [1:0]         txErrState,
  output logic [1:0]         rxErrState,
  output logic [SYNC_W-1:0]  syncVal,
  output logic [PRESC_W-1:0] prescVal,
  output logic               canTxPin,
  output logic               rxBitDom
);

  localparam int LANES = 2;

  logic             upV   [LANES];
  logic             downV [LANES];
  logic [CNT_W-1:0] cntV  [LANES];
  logic [1:0]       stV   [LANES];

  assign upV[0]   = txErrUp;
  assign downV[0] = txErrDown;
  assign upV[1]   = rxErrUp;
  assign downV[1] = rxErrDown;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    can_err_counter #(
      .CNT_W(CNT_W),
      .STEP(g == 0 ? TX_STEP : RX_STEP),
      .WARN_LVL(WARN_LVL),
      .PASS_LVL(PASS_LVL),
      .OFF_LVL(OFF_LVL)
    ) uCnt (
      .clk(clk),
      .rstN(rstN),
      .clr(strb.clrErr),
      .up(upV[g]),
      .down(downV[g]),
      .cnt(cntV[g]),
      .state(stV[g])
    );
  end

  assign txErrCnt   = cntV[0];
  assign rxErrCnt   = cntV[1];
  assign txErrState = stV[0];
  assign rxErrState = stV[1];
  assign statBusOff = (stV[0] == ERR_BUSOFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statTx <= 1'b0;
      statRx <= 1'b0;
    end else begin
      statTx <= txBusy;
      statRx <= rxBusy;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncVal  <= '0;
      prescVal <= '0;
    end else begin
      if (strb.syncWr) syncVal <= wrData[SYNC_W-1:0];
      if (strb.prescWr) prescVal <= wrData[PRESC_W-1:0];
    end
  end

  logic txDomEff;
  assign txDomEff = txBitDom & ~strb.forceRec;
  assign canTxPin = txDomEff ? strb.txPol : ~strb.txPol;
  assign rxBitDom = ~(canRxPin ^ strb.rxPol);

endmodule

// File: rtl/can_mode_reg.sv
module can_mode_reg
  import can_mode_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W = 9,
  parameter int SYNC_W = 8,
  parameter int PRESC_W = 6,
  parameter int TX_STEP = 8,
  parameter int RX_STEP = 1,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128,
  parameter int OFF_LVL = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               protoAck,
  input  logic               txBusy,
  input  logic               rxBusy,
  input  logic               txErrUp,
  input  logic               txErrDown,
  input  logic               rxErrUp,
  input  logic               rxErrDown,
  input  logic               txBitDom,
  input  logic               canRxPin,
  output logic               modeInit,
  output logic               modeSleep,
  output logic               modeStop,
  output logic               statInit,
  output logic               statBusOff,
  output logic               statTx,
  output logic               statRx,
  output logic [CNT_W-1:0]   txErrCnt,
  output logic [CNT_W-1:0]   rxErrCnt,
  output logic [1:0]         txErrState,
  output logic [1:0]         rxErrState,
  output logic [SYNC_W-1:0]  syncVal,
  output logic [PRESC_W-1:0] prescVal,
  output logic               canTxPin,
  output logic               rxBitDom
);

  modeStrobe_t strb;

  can_mode_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .wrEn(wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .protoAck(protoAck),
    .modeInit(modeInit),
    .modeSleep(modeSleep),
    .modeStop(modeStop),
    .statInit(statInit),
    .strb(strb)
  );

  can_mode_dp #(
    .DATA_W(DATA_W),
    .CNT_W(CNT_W),
    .SYNC_W(SYNC_W),
    .PRESC_W(PRESC_W),
    .TX_STEP(TX_STEP),
    .RX_STEP(RX_STEP),
    .WARN_LVL(WARN_LVL),
    .PASS_LVL(PASS_LVL),
    .OFF_LVL(OFF_LVL)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wrData(wrData),
    .txBusy(txBusy),
    .rxBusy(rxBusy),
    .txErrUp(txErrUp),
    .txErrDown(txErrDown),
    .rxErrUp(rxErrUp),
    .rxErrDown(rxErrDown),
    .txBitDom(txBitDom),
    .canRxPin(canRxPin),
    .statBusOff(statBusOff),
    .statTx(statTx),
    .statRx(statRx),
    .txErrCnt(txErrCnt),
    .rxErrCnt(rxErrCnt),
    .txErrState(txErrState),
    .rxErrState(rxErrState),
    .syncVal(syncVal),
    .prescVal(prescVal),
    .canTxPin(canTxPin),
    .rxBitDom(rxBitDom)
  );

endmodule

// File: rtl/can_mode_reg_chk.sv
module can_mode_reg_chk
  import can_mode_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int SYNC_W = 8,
  parameter int PRESC_W = 6,
  parameter int OFF_LVL = 256
) (
  input logic               clk,
  input logic               rstN,
  input logic               protoAck,
  input logic               modeInit,
  input logic               modeSleep,
  input logic               modeStop,
  input logic               statInit,
  input logic               statBusOff,
  input logic [CNT_W-1:0]   txErrCnt,
  input logic [CNT_W-1:0]   rxErrCnt,
  input logic [SYNC_W-1:0]  syncVal,
  input logic [PRESC_W-1:0] prescVal,
  input logic               canTxPin,
  input modeStrobe_t        strb
);

  p_busoff_r1: assert property (@(posedge clk) disable iff (!rstN)
    statBusOff == (int'(txErrCnt) >= OFF_LVL));

  p_init_needs_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statInit) |-> $past(protoAck));

  p_init_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!modeInit && !modeStop) |=> !statInit);

  p_tx_recessive_r4: assert property (@(posedge clk) disable iff (!rstN)
    statInit |-> (canTxPin == ~strb.txPol));

  p_bt_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    !statInit |=> ($stable(syncVal) && $stable(prescVal)));

  p_err_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    statInit |=> (txErrCnt == '0 && rxErrCnt == '0));

  p_stop_from_sleep_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeStop) |-> $past(modeSleep));

endmodule

bind can_mode_reg can_mode_reg_chk #(
  .CNT_W(CNT_W),
  .SYNC_W(SYNC_W),
  .PRESC_W(PRESC_W),
  .OFF_LVL(OFF_LVL)
) uChk (.*);

// File: tb/can_mode_reg_test.sv
`timescale 1ns/1ps
module can_mode_reg_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       protoAck = 1'b0;
  logic       txBusy = 1'b0;
  logic       rxBusy = 1'b0;
  logic       txErrUp = 1'b0;
  logic       txErrDown = 1'b0;
  logic       rxErrUp = 1'b0;
  logic       rxErrDown = 1'b0;
  logic       txBitDom = 1'b0;
  logic       canRxPin = 1'b1;

  logic       modeInit, modeSleep, modeStop, statInit, statBusOff, statTx, statRx;
  logic [8:0] txErrCnt, rxErrCnt;
  logic [1:0] txErrState, rxErrState;
  logic [7:0] syncVal;
  logic [5:0] prescVal;
  logic       canTxPin, rxBitDom;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_mode_reg uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .protoAck(protoAck), .txBusy(txBusy), .rxBusy(rxBusy),
    .txErrUp(txErrUp), .txErrDown(txErrDown), .rxErrUp(rxErrUp), .rxErrDown(rxErrDown),
    .txBitDom(txBitDom), .canRxPin(canRxPin),
    .modeInit(modeInit), .modeSleep(modeSleep), .modeStop(modeStop),
    .statInit(statInit), .statBusOff(statBusOff), .statTx(statTx), .statRx(statRx),
    .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt), .txErrState(txErrState), .rxErrState(rxErrState),
    .syncVal(syncVal), .prescVal(prescVal), .canTxPin(canTxPin), .rxBitDom(rxBitDom)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ackPulse();
    @(negedge clk);
    protoAck = 1'b1;
    @(negedge clk);
    protoAck = 1'b0;
  endtask

  // hold an error strobe for n cycles: 0 txUp, 1 txDown, 2 rxUp, 3 rxDown
  task automatic holdErr(int sel, int n);
    @(negedge clk);
    case (sel)
      0: txErrUp = 1'b1;
      1: txErrDown = 1'b1;
      2: rxErrUp = 1'b1;
      default: rxErrDown = 1'b1;
    endcase
    repeat (n) @(negedge clk);
    txErrUp = 1'b0; txErrDown = 1'b0; rxErrUp = 1'b0; rxErrDown = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12", "modeInit after reset", modeInit, 0);
    chk("R12", "modeStop after reset", modeStop, 0);
    chk("R3", "statInit after reset", statInit, 0);
    chk("R11", "txErrCnt after reset", txErrCnt, 0);
    chk("R5", "syncVal after reset", syncVal, 0);
    chk("R12", "canTxPin recessive after reset", canTxPin, 1);
  endtask

  task automatic t_status();
    @(negedge clk);
    txBusy = 1'b1;
    @(negedge clk);
    chk("R2", "statTx follows txBusy", statTx, 1);
    chk("R2", "statRx idle", statRx, 0);
    txBusy = 1'b0; rxBusy = 1'b1;
    @(negedge clk);
    chk("R2", "statTx drops", statTx, 0);
    chk("R2", "statRx follows rxBusy", statRx, 1);
    rxBusy = 1'b0;
    @(negedge clk);
    chk("R2", "statRx drops", statRx, 0);
  endtask

  task automatic t_errcount();
    holdErr(0, 11);
    chk("R11", "tx 11 steps", txErrCnt, 88);
    chk("R10", "tx 88 active", txErrState, 0);
    holdErr(0, 1);
    chk("R10", "tx 96 warning", txErrState, 1);
    holdErr(0, 3);
    chk("R10", "tx 120 warning", txErrState, 1);
    holdErr(0, 1);
    chk("R10", "tx 128 passive", txErrState, 2);
    holdErr(0, 15);
    chk("R11", "tx 248", txErrCnt, 248);
    chk("R1", "busoff clear at 248", statBusOff, 0);
    holdErr(0, 1);
    chk("R1", "busoff set at 256", statBusOff, 1);
    chk("R10", "tx 256 busoff state", txErrState, 3);
    holdErr(1, 1);
    chk("R11", "tx down to 255", txErrCnt, 255);
    chk("R1", "busoff clear at 255", statBusOff, 0);
    chk("R10", "tx 255 passive", txErrState, 2);
    holdErr(0, 40);
    chk("R11", "tx saturates at 511", txErrCnt, 511);
    holdErr(2, 95);
    chk("R11", "rx 95 single steps", rxErrCnt, 95);
    chk("R10", "rx 95 active", rxErrState, 0);
    holdErr(2, 1);
    chk("R10", "rx 96 warning", rxErrState, 1);
    holdErr(3, 2);
    chk("R11", "rx down to 94", rxErrCnt, 94);
    chk("R10", "rx 94 active", rxErrState, 0);
  endtask

  task automatic t_init();
    txBitDom = 1'b1;
    writeReg(0, 8'h01);
    chk("R12", "modeInit set by write", modeInit, 1);
    chk("R3", "statInit waits for ack", statInit, 0);
    chk("R6", "counter kept before ack", txErrCnt, 511);
    chk("R8", "dominant low before ack", canTxPin, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R3", "statInit still low during ack delay", statInit, 0);
    end
    ackPulse();
    chk("R3", "statInit after ack", statInit, 1);
    chk("R4", "tx pin recessive while initialized", canTxPin, 1);
    @(negedge clk);
    chk("R6", "tx counter cleared", txErrCnt, 0);
    chk("R6", "rx counter cleared", rxErrCnt, 0);
    chk("R6", "tx state reset", txErrState, 0);
    chk("R1", "busoff clear after init", statBusOff, 0);
    holdErr(0, 3);
    chk("R6", "tx counter held at 0", txErrCnt, 0);
    txBitDom = 1'b0;
  endtask

  task automatic t_bittiming();
    writeReg(1, 8'h55);
    chk("R5", "sync written in init", syncVal, 8'h55);
    writeReg(2, 8'hEA);
    chk("R5", "prescaler written in init", prescVal, 6'h2A);
    writeReg(0, 8'h00);
    chk("R3", "statInit one more cycle after release", statInit, 1);
    @(negedge clk);
    chk("R3", "statInit clears after release", statInit, 0);
    writeReg(1, 8'h33);
    chk("R5", "sync write ignored", syncVal, 8'h55);
    writeReg(2, 8'h11);
    chk("R5", "prescaler write ignored", prescVal, 6'h2A);
    ackPulse();
    @(negedge clk);
    chk("R3", "stray ack ignored", statInit, 0);
  endtask

  task automatic t_polarity();
    for (int pol = 0; pol < 4; pol++) begin
      writeReg(0, pol << 3);
      for (int lv = 0; lv < 2; lv++) begin
        canRxPin = lv[0];
        txBitDom = lv[0];
        #1;
        chk("R7", "rxBitDom", rxBitDom, (pol & 1) ? lv : 1 - lv);
        chk("R8", "canTxPin", canTxPin, (pol & 2) ? lv : 1 - lv);
      end
    end
    txBitDom = 1'b1;
    writeReg(0, 8'h11);
    ackPulse();
    chk("R4", "recessive low with inverted polarity", canTxPin, 0);
    writeReg(0, 8'h10);
    @(negedge clk);
    chk("R8", "dominant high after init release", canTxPin, 1);
    txBitDom = 1'b0;
    canRxPin = 1'b1;
    writeReg(0, 8'h00);
  endtask

  task automatic t_stop();
    writeReg(0, 8'h04);
    chk("R9", "stop refused without sleep", modeStop, 0);
    writeReg(0, 8'h02);
    chk("R12", "sleep set", modeSleep, 1);
    writeReg(0, 8'h06);
    chk("R9", "stop accepted from sleep", modeStop, 1);
    ackPulse();
    chk("R3", "stop request acknowledged", statInit, 1);
    writeReg(0, 8'h04);
    chk("R9", "stop kept when sleep cleared", modeStop, 1);
    chk("R12", "sleep cleared", modeSleep, 0);
    writeReg(0, 8'h00);
    chk("R9", "stop cleared by write", modeStop, 0);
    @(negedge clk);
    chk("R3", "statInit clears after stop released", statInit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_status();
    t_errcount();
    t_init();
    t_bittiming();
    t_polarity();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule